// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Split and Retry Handling

This block decides which of several masters may drive the address phase of a pipelined shared bus. Each master raises a request line. The arbiter answers with a one-hot grant vector and a registered owner index. The grant moves only on clock edges where the bus ready signal is high, because a master takes the address bus only when its grant and ready are both high at a rising edge. The owner index follows the grant one ready edge later, so data-phase steering logic can use it directly.

Priority is fixed: the master with the lowest index wins. The arbiter also watches the slave response code. A RETRY response leaves eligibility as it is, so the retried master competes again at its normal priority. A SPLIT response parks the owning master in a split mask. The masked master takes no part in arbitration until the slave raises that master's bit on the unsplit input. While it is parked, masters of lower priority can win. When no eligible master requests the bus, the grant goes to a designated default master.

Top module: `bus_arbiter_split`

## Requirements
- R1: While reset is high, and on the first cycle after it, grant is the one-hot vector with only bit DEFAULT_MASTER set, owner equals DEFAULT_MASTER, and no master is split.
- R2: Out of reset, exactly one grant bit is high on every cycle.
- R3: grant and owner change only on rising edges where bus_ready is 1. When bus_ready is 0 they hold their values.
- R4: On a ready edge, the eligible requester with the lowest index receives the grant. A master is eligible when its req bit is 1 and it is not split.
- R5: On a ready edge, owner takes the index of the master whose grant bit was high just before that edge.
- R6: The response code is 2 bits wide: OKAY=00, ERROR=01, RETRY=10, SPLIT=11. OKAY, ERROR and RETRY leave the split mask unchanged, so after a RETRY only a master of higher priority can displace the retried one.
- R7: SPLIT (11) seen with bus_ready=1 marks the current owner as split. That master is already excluded from the arbitration on the same edge.
- R8: A 1 on bit i of unsplit clears master i's split mark. Master i is eligible again in the arbitration on that same edge. An unsplit bit for a master that is not split has no effect.
- R9: When no eligible master requests the bus on a ready edge, the grant goes to DEFAULT_MASTER, even if that master is split.
- R10: If the owner is split and its unsplit bit is high on the same edge, the split mark wins and the master stays excluded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Bus request, one bit per master |
| bus_ready | input | 1 | Bus ready; transfers and handovers happen when high |
| resp | input | 2 | Slave response code (OKAY 00, ERROR 01, RETRY 10, SPLIT 11) |
| unsplit | input | N_MASTERS | Slave indication that a split master may retry, one bit per master |
| grant | output | N_MASTERS | One-hot registered grant |
| owner | output | IDX_W | Registered index of the master owning the current transfer |

## Verification
On every cycle, assertions check the one-hot grant, that grant and owner hold through wait states, that owner tracks the previous grant, that a split master is marked and loses its grant, that unsplit clears the mark, and that the default master is chosen when nobody else is eligible. Which master actually wins depends on the history of split marks and on the priority order. Only the bench's reference model can confirm that, using directed scenarios: a retry under contention, a split that lets a lower-priority master win, an unsplit followed by a return to priority order, split and unsplit on the same edge, and every master parked at once.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } slave_resp_e;
endpackage

// File: rtl/arb_prio_pick.sv
// Lowest-index-first picker: one-hot winner, its index, and an any flag.
module arb_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             found
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | cand[i];
    assign pick_oh[i] = cand[i] & ~seen[i];
  end

  assign found = seen[N];

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_oh[i]) pick_idx = pick_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb_split_mask.sv
// Per-master split mask: set wins over clear on the same bit.
module arb_split_mask #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_next
);
  assign mask_next = (mask_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next;
  end

  // R8: a cleared bit (not simultaneously set) is gone on the next cycle
  a_r8_unsplit_clears: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(clr_vec & ~set_vec)) == '0));

  // R10: a set bit is present on the next cycle regardless of clears
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((mask_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/bus_arbiter_split.sv
module bus_arbiter_split
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS      = 4,
  parameter int DEFAULT_MASTER = 0,
  parameter int IDX_W          = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 bus_ready,
  input  logic [1:0]           resp,
  input  logic [N_MASTERS-1:0] unsplit,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]     owner
);
  localparam logic [N_MASTERS-1:0] DEF_OH = N_MASTERS'(1) << DEFAULT_MASTER;
  localparam logic [IDX_W-1:0]     DEF_IX = IDX_W'(DEFAULT_MASTER);

  logic [N_MASTERS-1:0] owner_oh, split_set, mask_q, mask_next;
  logic [N_MASTERS-1:0] cand, win_oh, next_grant, grant_dec_oh;
  logic [IDX_W-1:0]     win_idx, grant_idx;
  logic                 win_found, grant_nonzero, split_now;

  assign split_now = bus_ready && (slave_resp_e'(resp) == RSP_SPLIT);
  assign owner_oh  = N_MASTERS'(1) << owner;
  assign split_set = split_now ? owner_oh : '0;

  arb_split_mask #(.N(N_MASTERS)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (split_set),
    .clr_vec   (unsplit),
    .mask_q    (mask_q),
    .mask_next (mask_next)
  );

  assign cand = req & ~mask_next;

  arb_prio_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .cand     (cand),
    .pick_oh  (win_oh),
    .pick_idx (win_idx),
    .found    (win_found)
  );

  // Encoder for the current one-hot grant (reuses the picker)
  arb_prio_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_enc (
    .cand     (grant),
    .pick_oh  (grant_dec_oh),
    .pick_idx (grant_idx),
    .found    (grant_nonzero)
  );

  assign next_grant = win_found ? win_oh : DEF_OH;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= DEF_OH;
      owner <= DEF_IX;
    end else if (bus_ready) begin
      grant <= next_grant;
      owner <= grant_idx;
    end
  end

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    grant_nonzero && (grant_dec_oh == grant));

  a_r3_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> ($stable(grant) && $stable(owner)));

  a_r5_owner_tracks: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> (owner == $past(grant_idx)));

  a_r7_split_parks: assert property (@(posedge clk) disable iff (rst)
    split_now |=> (mask_q[$past(owner)] &&
                   (!grant[$past(owner)] || ($past(owner) == DEF_IX))));

  a_r9_default_idle: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !win_found) |=> (grant == DEF_OH));

  a_r4_masked_lose: assert property (@(posedge clk) disable iff (rst)
    ((grant & mask_q) == '0) || (grant == DEF_OH));
endmodule

// File: tb/bus_arbiter_split_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_split_tb_top;
  localparam int N   = 4;
  localparam int DEF = 0;
  localparam int IW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          bus_ready = 1'b1;
  logic [1:0]    resp = 2'b00;
  logic [N-1:0]  unsplit = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // model state
  int m_grant = DEF;
  int m_owner = DEF;
  int m_mask  = 0;

  always #4 clk = ~clk;

  bus_arbiter_split #(.N_MASTERS(N), .DEFAULT_MASTER(DEF)) dut_i (
    .clk(clk), .rst(rst), .req(req), .bus_ready(bus_ready),
    .resp(resp), .unsplit(unsplit), .grant(grant), .owner(owner)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_grant = DEF; m_owner = DEF; m_mask = 0;
    end else begin
      int nm;
      int win;
      nm = m_mask & ~int'(unsplit);
      if (bus_ready && resp == 2'b11) nm = nm | (1 << m_owner);
      if (bus_ready) begin
        win = -1;
        for (int i = N - 1; i >= 0; i--)
          if (req[i] && !nm[i]) win = i;
        if (win < 0) win = DEF;
        m_owner = m_grant;
        m_grant = win;
      end
      m_mask = nm;
    end
  end

  task automatic compare();
    checks++;
    if (grant !== N'(1 << m_grant)) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant, N'(1 << m_grant));
    end
    checks++;
    if (owner !== IW'(m_owner)) begin
      errors++;
      $display("FAIL %s owner actual=%0d expected=%0d", tag, owner, m_owner);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic rdy,
                      input logic [1:0] rs, input logic [N-1:0] us);
    req = r; bus_ready = rdy; resp = rs; unsplit = us;
    @(negedge clk);
    compare();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired in phase %s", tag);
    report();
  end

  initial begin
    // R1: reset state, then first cycle out of reset
    repeat (3) @(negedge clk);
    compare();
    rst = 1'b0;
    step('0, 1'b0, 2'b00, '0);

    // R4: fixed priority across patterns
    tag = "R4";
    step(4'b1000, 1, 2'b00, '0);
    step(4'b1100, 1, 2'b00, '0);
    step(4'b0110, 1, 2'b00, '0);
    step(4'b1111, 1, 2'b00, '0);
    step(4'b1010, 1, 2'b00, '0);

    // R3: wait states hold grant and owner
    tag = "R3";
    step(4'b0100, 0, 2'b00, '0);
    step(4'b1000, 0, 2'b00, '0);
    step(4'b1000, 1, 2'b00, '0);

    // R5: owner follows grant across handovers
    tag = "R5";
    step(4'b0001, 1, 2'b00, '0);
    step(4'b0010, 1, 2'b00, '0);
    step(4'b0010, 0, 2'b00, '0);
    step(4'b0100, 1, 2'b00, '0);

    // R6: retry and error keep priority order
    tag = "R6";
    step(4'b0001, 1, 2'b00, '0);
    step(4'b0011, 1, 2'b10, '0);
    step(4'b0011, 1, 2'b10, '0);
    step(4'b0110, 1, 2'b01, '0);
    step(4'b0110, 1, 2'b10, '0);

    // R7: split parks master 0, lower priority wins
    tag = "R7";
    step(4'b1111, 1, 2'b00, '0);
    step(4'b1111, 1, 2'b00, '0);
    step(4'b1111, 1, 2'b11, '0);
    step(4'b1111, 1, 2'b00, '0);
    step(4'b1111, 1, 2'b11, '0);
    step(4'b1111, 1, 2'b00, '0);

    // R8: unsplit restores eligibility; stray unsplit is harmless
    tag = "R8";
    step(4'b1111, 1, 2'b00, 4'b0001);
    step(4'b1111, 1, 2'b00, 4'b1000);
    step(4'b1110, 1, 2'b00, 4'b0010);
    step(4'b1110, 1, 2'b00, '0);

    // R9: default master when nobody eligible, even when split
    tag = "R9";
    step(4'b0000, 1, 2'b00, '0);
    step(4'b0000, 1, 2'b00, '0);
    step(4'b0001, 1, 2'b11, '0);
    step(4'b0001, 1, 2'b00, '0);
    step(4'b0001, 1, 2'b00, 4'b0001);

    // R10: split and unsplit of the owner on the same edge
    tag = "R10";
    step(4'b0011, 1, 2'b00, '0);
    step(4'b0011, 1, 2'b11, 4'b0001);
    step(4'b0011, 1, 2'b00, '0);
    step(4'b0011, 1, 2'b00, 4'b0001);
    step(4'b0011, 1, 2'b00, '0);

    // R2: mixed random traffic
    tag = "R2";
    for (int k = 0; k < 400; k++) begin
      logic [1:0] rs;
      rs = ($urandom_range(0, 7) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      step(N'($urandom), ($urandom_range(0, 3) != 0), rs,
           ($urandom_range(0, 3) == 0) ? N'($urandom) : '0);
    end
    report();
  end
endmodule